// File: doc/BRIEF.md
# Register-Controlled Watchdog Timer

This block is a watchdog timer that software controls through two 32-bit registers. One holds the action to take on expiry and a status flag. The other holds a down-counter measured in clock ticks. Software first loads the counter, then selects a non-zero action, which arms the watchdog. It stays alive by writing the counter again before the count runs out. Writing action zero stops the count.

When the count falls from one to zero, the block raises exactly one of three pulse outputs for one cycle: a general interrupt, a non-maskable interrupt, or a request for a full chip reset. The counter then waits at zero until it is reloaded. A counter write takes a fixed number of cycles to reach the counter, so software loads the counter before arming.

A status flag records whether the last chip reset was caused by the watchdog. It is cleared only by the power-on reset, so it survives the ordinary reset that the chip-reset request produces.

Registers are reached over a request/response stream. A request is accepted when `req_valid` and `req_ready` are both high, and every accepted request returns one response. At most one response is outstanding. While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and the response stays unchanged.

Top module: `wdog_periph`

## Requirements
- R1: After either reset the action field reads 0, the counter reads all ones (0xFFFFFFFF), all three pulse outputs are low and `rsp_valid` is low.
- R2: Reading offset 0x0 returns the action in bits [1:0] and the watchdog-reset flag in bit 31; all other bits read 0.
- R3: A value written to offset 0x4 reaches the counter exactly RELOAD_LAT cycles after the write is accepted. Reads accepted before then return the old count.
- R4: The counter drops by one each cycle only while the action is non-zero. With action 0 it holds its value.
- R5: In the cycle the counter first reads zero after counting down from one, the selected pulse output is high for exactly one cycle. The counter then stays at zero and no further pulse follows.
- R6: Action encoding: 1 pulses `irq_pulse_o`, 2 pulses `nmi_pulse_o`, 3 pulses `chip_rst_req_o`. Only the selected line rises.
- R7: A counter reload that lands in the same cycle as the one-to-zero step wins. No pulse is produced and the counter takes the new value.
- R8: The watchdog-reset flag (bit 31 of offset 0x0) is set by an expiry with action 3. `rst_n` does not clear it; only `por_n` does.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, no request is accepted, and `rsp_rdata` holds steady.
- R10: A read of offset 0x4 returns the live counter value from the cycle the request is accepted. A write returns a response with data 0.
- R11: Offsets other than 0x0 and 0x4, including offsets that are not word-aligned, ignore writes and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter ticks on it |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything including the flag |
| rst_n | input | 1 | Ordinary reset, active low, synchronous; leaves the watchdog-reset flag alone |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in the register window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumer can take it |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| irq_pulse_o | output | 1 | One-cycle general interrupt on expiry with action 1 |
| nmi_pulse_o | output | 1 | One-cycle non-maskable interrupt on expiry with action 2 |
| chip_rst_req_o | output | 1 | One-cycle full chip reset request on expiry with action 3 |

## Verification
Two events can fall in the same cycle: a delayed counter reload landing and the counter's one-to-zero step. The bench arms with a known count, then issues the keep-alive write exactly RELOAD_LAT cycles before the expiry edge, so the reload reaches the counter on that edge. It judges the outcome by the absence of any pulse and by the counter value read afterwards, which must be the new value minus the cycles elapsed since the reload. A disable write accepted mid-count is checked the same way: the count frozen at the expected value, and no pulse afterwards.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W     = 32;
  localparam int CTRL_WORD  = 0;
  localparam int TIMER_WORD = 1;
  localparam int FLAG_BIT   = 31;

  typedef enum logic [1:0] {
    ACT_OFF     = 2'd0,
    ACT_IRQ     = 2'd1,
    ACT_NMI     = 2'd2,
    ACT_CHIPRST = 2'd3
  } wd_action_e;
endpackage

// File: rtl/wdog_bus_slave.sv
module wdog_bus_slave
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              sys_rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  input  wd_action_e        cur_action,
  input  logic [CNT_W-1:0]  cur_count,
  input  logic              cause_flag,
  output logic              ctrl_we,
  output wd_action_e        ctrl_wdata,
  output logic              tmr_we,
  output logic [CNT_W-1:0]  tmr_wdata
);
  localparam int WORD_W = ADDR_W - 2;

  logic              accept;
  logic              aligned;
  logic [WORD_W-1:0] word;
  logic              hit_ctrl;
  logic              hit_tmr;
  logic [DATA_W-1:0] rd_next;

  // a new request only while no response is stuck waiting
  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;

  assign word     = req_addr[ADDR_W-1:2];
  assign aligned  = (req_addr[1:0] == 2'b00);
  assign hit_ctrl = aligned && (word == WORD_W'(CTRL_WORD));
  assign hit_tmr  = aligned && (word == WORD_W'(TIMER_WORD));

  assign ctrl_we    = accept && req_write && hit_ctrl;
  assign ctrl_wdata = wd_action_e'(req_wdata[1:0]);
  assign tmr_we     = accept && req_write && hit_tmr;
  assign tmr_wdata  = req_wdata[CNT_W-1:0];

  always_comb begin
    rd_next = '0;
    if (!req_write) begin
      if (hit_ctrl) begin
        rd_next[1:0]     = cur_action;
        rd_next[FLAG_BIT] = cause_flag;
      end else if (hit_tmr) begin
        rd_next[CNT_W-1:0] = cur_count;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sys_rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= rd_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_reload_pipe.sv
module wdog_reload_pipe #(
  parameter int W   = 32,
  parameter int LAT = 3
) (
  input  logic         clk,
  input  logic         sys_rst,
  input  logic         in_en,
  input  logic [W-1:0] in_val,
  output logic         out_en,
  output logic [W-1:0] out_val
);
  logic         vld [LAT];
  logic [W-1:0] dat [LAT];

  generate
    for (genvar s = 0; s < LAT; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (sys_rst) vld[0] <= 1'b0;
          else         vld[0] <= in_en;
        end
        always_ff @(posedge clk) begin
          if (in_en) dat[0] <= in_val;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (sys_rst) vld[s] <= 1'b0;
          else         vld[s] <= vld[s-1];
        end
        always_ff @(posedge clk) begin
          dat[s] <= dat[s-1];
        end
      end
    end
  endgenerate

  assign out_en  = vld[LAT-1];
  assign out_val = dat[LAT-1];
endmodule

// File: rtl/wdog_count_core.sv
module wdog_count_core
  import wdog_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             sys_rst,
  input  logic             por_n,
  input  wd_action_e       action,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             irq_pulse,
  output logic             nmi_pulse,
  output logic             chip_req,
  output logic             cause_flag
);
  logic armed;
  logic expire;

  assign armed  = (action != ACT_OFF);
  // a reload landing on the final step takes priority
  assign expire = armed && !load_en && (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (sys_rst)                          count <= '1;
    else if (load_en)                     count <= load_val;
    else if (armed && (count != '0))      count <= count - CNT_W'(1);
  end

  generate
    for (genvar a = 1; a < 4; a++) begin : g_act
      logic q;
      always_ff @(posedge clk) begin
        if (sys_rst) q <= 1'b0;
        else         q <= expire && (action == wd_action_e'(a));
      end
    end
  endgenerate

  assign irq_pulse = g_act[1].q;
  assign nmi_pulse = g_act[2].q;
  assign chip_req  = g_act[3].q;

  // lives in the power-on domain only
  always_ff @(posedge clk) begin
    if (!por_n)                                   cause_flag <= 1'b0;
    else if (expire && (action == ACT_CHIPRST))   cause_flag <= 1'b1;
  end
endmodule

// File: rtl/wdog_periph.sv
module wdog_periph
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int CNT_W      = 32,
  parameter int RELOAD_LAT = 3
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              irq_pulse_o,
  output logic              nmi_pulse_o,
  output logic              chip_rst_req_o
);
  logic             sys_rst;
  wd_action_e       action_q;
  logic             ctrl_we;
  wd_action_e       ctrl_wdata;
  logic             tmr_we;
  logic [CNT_W-1:0] tmr_wdata;
  logic             load_en;
  logic [CNT_W-1:0] load_val;
  logic [CNT_W-1:0] count;
  logic             cause_flag;

  assign sys_rst = !rst_n || !por_n;

  always_ff @(posedge clk) begin
    if (sys_rst)      action_q <= ACT_OFF;
    else if (ctrl_we) action_q <= ctrl_wdata;
  end

  wdog_bus_slave #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_bus (
    .clk        (clk),
    .sys_rst    (sys_rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_rdata  (rsp_rdata),
    .cur_action (action_q),
    .cur_count  (count),
    .cause_flag (cause_flag),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .tmr_we     (tmr_we),
    .tmr_wdata  (tmr_wdata)
  );

  wdog_reload_pipe #(.W(CNT_W), .LAT(RELOAD_LAT)) u_pipe (
    .clk     (clk),
    .sys_rst (sys_rst),
    .in_en   (tmr_we),
    .in_val  (tmr_wdata),
    .out_en  (load_en),
    .out_val (load_val)
  );

  wdog_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .sys_rst    (sys_rst),
    .por_n      (por_n),
    .action     (action_q),
    .load_en    (load_en),
    .load_val   (load_val),
    .count      (count),
    .irq_pulse  (irq_pulse_o),
    .nmi_pulse  (nmi_pulse_o),
    .chip_req   (chip_rst_req_o),
    .cause_flag (cause_flag)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             sys_rst,
  input logic             por_n,
  input logic [1:0]       action,
  input logic [CNT_W-1:0] count,
  input logic             load_en,
  input logic [CNT_W-1:0] load_val,
  input logic             irq,
  input logic             nmi,
  input logic             chip,
  input logic             cause_flag,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [31:0]      rsp_rdata
);
  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (action == 2'd0 && !load_en) |=> $stable(count));

  // R7
  reload_wins_chk: assert property (@(posedge clk) disable iff (sys_rst)
    load_en |=> (count == $past(load_val)) && !irq && !nmi && !chip);

  // R5
  one_cycle_pulse_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (irq || nmi || chip) |=> !(irq || nmi || chip));

  // R5
  pulse_at_zero_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (irq || nmi || chip) |-> (count == '0));

  // R6
  single_line_chk: assert property (@(posedge clk) disable iff (sys_rst)
    $onehot0({irq, nmi, chip}));

  // R8
  flag_on_chip_chk: assert property (@(posedge clk) disable iff (sys_rst)
    chip |-> cause_flag);

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    !$fell(cause_flag));

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (sys_rst)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata));
endmodule

bind wdog_periph wdog_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .sys_rst    (sys_rst),
  .por_n      (por_n),
  .action     (action_q),
  .count      (count),
  .load_en    (load_en),
  .load_val   (load_val),
  .irq        (irq_pulse_o),
  .nmi        (nmi_pulse_o),
  .chip       (chip_rst_req_o),
  .cause_flag (cause_flag),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata)
);

// File: tb/tb_wdog_periph.sv
`timescale 1ns/1ps
module tb_wdog_periph;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        por_n, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [3:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_ready;
  logic [31:0] rsp_rdata;
  logic        irq_pulse_o, nmi_pulse_o, chip_rst_req_o;
  logic [31:0] rd;
  int          n_chk = 0;
  int          n_err = 0;

  always #10 clk = ~clk;

  wdog_periph #(.ADDR_W(4), .CNT_W(32), .RELOAD_LAT(LAT)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_pulse_o(irq_pulse_o), .nmi_pulse_o(nmi_pulse_o),
    .chip_rst_req_o(chip_rst_req_o)
  );

  function automatic logic [2:0] exp_line(input logic [1:0] a);
    return (a == 2'd0) ? 3'b000 : 3'(1 << (a - 1));
  endfunction

  function automatic logic [31:0] exp_ctrl(input logic flag, input logic [1:0] a);
    return {flag, 29'd0, a};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // caller stands at a negedge; returns at the negedge after acceptance
  task automatic bus_op(input logic wr, input logic [3:0] a, input logic [31:0] d,
                        output logic [31:0] r);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    r = rsp_rdata;
  endtask

  task automatic watch(input int n, input int at, input logic [2:0] line, input string tag);
    int hit = -1;
    int hits = 0;
    logic [2:0] seen = 3'b000;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if ({chip_rst_req_o, nmi_pulse_o, irq_pulse_o} != 3'b000) begin
        hits++;
        if (hit < 0) begin
          hit = j;
          seen = {chip_rst_req_o, nmi_pulse_o, irq_pulse_o};
        end
      end
    end
    chk({tag, " cycle"}, hit, (at > 0) ? at : -1);
    chk({tag, " count"}, hits, (at > 0) ? 1 : 0);
    if (at > 0) chk({tag, " line"}, {29'd0, seen}, {29'd0, line});
  endtask

  task automatic arm(input logic [1:0] a, input int v);
    logic [31:0] r;
    bus_op(1'b1, 4'h4, v, r);
    repeat (LAT) @(negedge clk);
    bus_op(1'b1, 4'h0, {30'd0, a}, r);
  endtask

  task automatic chip_reset_seq(input string tag);
    logic [31:0] r;
    bus_op(1'b0, 4'h0, 0, r);
    chk({tag, " R8 flag set"}, r, exp_ctrl(1'b1, 2'd3));
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    bus_op(1'b0, 4'h0, 0, r);
    chk({tag, " R8 flag survives rst_n"}, r, exp_ctrl(1'b1, 2'd0));
    bus_op(1'b0, 4'h4, 0, r);
    chk({tag, " R1 count after rst_n"}, r, 32'hFFFF_FFFF);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    bus_op(1'b0, 4'h0, 0, r);
    chk({tag, " R8 flag cleared by por_n"}, r, exp_ctrl(1'b0, 2'd0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual running expected done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    por_n = 1'b0; rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rsp_ready = 1'b1;
    repeat (4) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;

    // R1 reset state
    chk("R1 pulses", {29'd0, chip_rst_req_o, nmi_pulse_o, irq_pulse_o}, 32'd0);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    bus_op(1'b0, 4'h0, 0, rd);
    chk("R1 R2 ctrl after reset", rd, exp_ctrl(1'b0, 2'd0));
    bus_op(1'b0, 4'h4, 0, rd);
    chk("R1 count after reset", rd, 32'hFFFF_FFFF);

    // R3 reload latency, R10 write response
    bus_op(1'b1, 4'h4, 32'd100, rd);
    chk("R10 write response data", rd, 32'd0);
    for (int k = 1; k <= LAT; k++) begin
      bus_op(1'b0, 4'h4, 0, rd);
      chk($sformatf("R3 old count read %0d", k), rd, 32'hFFFF_FFFF);
    end
    bus_op(1'b0, 4'h4, 0, rd);
    chk("R3 new count visible", rd, 32'd100);
    // R4 hold while off
    repeat (10) @(negedge clk);
    bus_op(1'b0, 4'h4, 0, rd);
    chk("R4 count holds with action 0", rd, 32'd100);

    // R5 R6 directed: each action
    for (int a = 1; a <= 3; a++) begin
      arm(2'(a), 6);
      watch(8, 6, exp_line(2'(a)), $sformatf("R5 R6 act%0d", a));
      if (a == 3) begin
        chip_reset_seq("directed");
      end else begin
        bus_op(1'b0, 4'h4, 0, rd);
        chk($sformatf("R5 stays zero act%0d", a), rd, 32'd0);
        watch(10, 0, 3'b000, $sformatf("R5 no repeat act%0d", a));
        bus_op(1'b1, 4'h0, 0, rd);
      end
    end

    // random: R5 R6 R10
    for (int it = 0; it < 12; it++) begin
      logic [1:0] a;
      int v, m;
      a = 2'(1 + ($urandom % 3));
      v = 4 + int'($urandom % 30);
      m = int'($urandom % (v - 2));
      arm(a, v);
      repeat (m) @(negedge clk);
      bus_op(1'b0, 4'h4, 0, rd);
      chk($sformatf("R10 live count it%0d", it), rd, v - m);
      watch(v - (m + 1) + 2, v - (m + 1), exp_line(a), $sformatf("R5 R6 rand it%0d", it));
      if (a == 2'd3) chip_reset_seq($sformatf("rand it%0d", it));
      else           bus_op(1'b1, 4'h0, 0, rd);
    end

    // keep-alive before expiry
    arm(2'd1, 10);
    repeat (4) @(negedge clk);
    bus_op(1'b1, 4'h4, 32'd10, rd);
    watch(LAT + 12, LAT + 10, 3'b001, "R3 keep-alive");
    bus_op(1'b1, 4'h0, 0, rd);

    // disable mid-count
    arm(2'd2, 20);
    repeat (5) @(negedge clk);
    bus_op(1'b1, 4'h0, 0, rd);
    bus_op(1'b0, 4'h4, 0, rd);
    chk("R4 frozen after disable", rd, 32'd14);
    watch(30, 0, 3'b000, "R4 no pulse after disable");
    bus_op(1'b0, 4'h4, 0, rd);
    chk("R4 still frozen", rd, 32'd14);

    // R7 reload lands on the expiry edge
    arm(2'd1, 12);
    repeat (12 - 4) @(negedge clk);
    bus_op(1'b1, 4'h4, 32'd50, rd);
    watch(10, 0, 3'b000, "R7 collision no pulse");
    bus_op(1'b0, 4'h4, 0, rd);
    chk("R7 counter took new value", rd, 32'd43);
    bus_op(1'b1, 4'h0, 0, rd);

    // R11 unmapped offsets
    bus_op(1'b1, 4'h8, 32'h3, rd);
    bus_op(1'b1, 4'h1, 32'h3, rd);
    bus_op(1'b0, 4'h0, 0, rd);
    chk("R11 write to unmapped ignored", rd, exp_ctrl(1'b0, 2'd0));
    bus_op(1'b0, 4'h8, 0, rd);
    chk("R11 unmapped read", rd, 32'd0);
    bus_op(1'b0, 4'h5, 0, rd);
    chk("R11 misaligned read", rd, 32'd0);

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    bus_op(1'b0, 4'h4, 0, rd);
    chk("R9 rsp held valid", {31'd0, rsp_valid}, 32'd1);
    chk("R9 req_ready low", {31'd0, req_ready}, 32'd0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h0; req_wdata = 32'h2;
    repeat (2) @(negedge clk);
    chk("R9 rsp still valid", {31'd0, rsp_valid}, 32'd1);
    chk("R9 rdata stable", rsp_rdata, rd);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    bus_op(1'b0, 4'h0, 0, rd);
    chk("R9 blocked write not taken", rd, exp_ctrl(1'b0, 2'd0));

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule